// File: doc/BRIEF.md
# ATA Device Task-File Register Block

This block is the device-side register file that a host talks to over an ATA-style parallel bus. Two chip selects and a 3-bit register address pick one register in either the command block or the control block. Host read and write strobes are single-cycle enables that are synchronous to the device clock. The block stores the task-file registers: features, sector count, sector number, the two cylinder bytes and device/head. It also keeps the Status and Error registers and the Device Control byte.

On its firmware side, a controller can load Status and Error, raise an interrupt, and see each command opcode the moment the host writes it. The interrupt line and the read data bus each have their own output-enable. The surrounding pad logic turns a low enable into high impedance. The device answers only while the device-select bit in device/head matches its strapped identity.

Top module: `ata_taskfile`

## Requirements
- R1: With only `cs_cmd` asserted, addresses 2, 3, 4, 5 and 6 hold sector count, sector number, cylinder low, cylinder high and device/head. Writing a byte to one of them and then reading the same address returns that byte with `rdata_oe` = 1.
- R2: With only `cs_ctl` asserted, address 6 is the single control register. A read there returns Status, and a write there loads Device Control. Control addresses other than 6, and any access with both or neither chip select asserted, leave `rdata_oe` = 0 and change no register.
- R3: Bit 4 of device/head selects the device, and the block is selected when that bit equals `DEV_ID`. While deselected, reads give `rdata_oe` = 0, `irq_oe` = 0, and a Command write neither pulses `cmd_go` nor clears a pending interrupt. Writes to addresses 1 to 6 are still stored.
- R4: Status bits are BSY = bit 7, DRDY = bit 6, DF = bit 5, DRQ = bit 3 and ERR = bit 0. After reset, Status reads 8'h40 (only DRDY set) and Error reads `DIAG_CODE` (default 8'h01).
- R5: A selected host write to address 7 sets Status bit 7 (BSY) and leaves the other bits unchanged. In the following cycle, `cmd_go` is high for exactly one cycle and `cmd_op` carries the written byte. A `fw_status_we` cycle loads Status from `fw_status`.
- R6: A `fw_irq_set` cycle makes the interrupt pending. While `irq_oe` = 1, `irq_o` shows the pending state.
- R7: A pending interrupt is cleared by hardware reset, by a selected read of Status (address 7), by a selected Command write, or by a Device Control write with bit 2 (soft reset) set. `srst_o` follows bit 2 of Device Control.
- R8: A read of the control register returns the same value as Status and leaves a pending interrupt pending.
- R9: `irq_oe` is 0 while Device Control bit 1 (interrupt disable) is 1. Clearing that bit again exposes an interrupt that was still pending.
- R10: A read at address 1 returns the Error register, which `fw_error_we` loads. A write at address 1 goes to the features register and appears on `fw_feat`. It does not change what address 1 reads back.
- R11: Address 0 (data) of the command block drives nothing on read (`rdata_oe` = 0), and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| cs_cmd | input | 1 | Command block chip select, active high |
| cs_ctl | input | 1 | Control block chip select, active high |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Host read strobe, one cycle |
| wr_en | input | 1 | Host write strobe, one cycle |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| rdata_oe | output | 1 | Read data bus drive enable |
| irq_o | output | 1 | Interrupt request level |
| irq_oe | output | 1 | Interrupt pin drive enable |
| fw_status_we | input | 1 | Firmware load of Status |
| fw_status | input | 8 | Status value from firmware |
| fw_error_we | input | 1 | Firmware load of Error |
| fw_error | input | 8 | Error value from firmware |
| fw_irq_set | input | 1 | Firmware interrupt request |
| cmd_go | output | 1 | One-cycle pulse after a Command write |
| cmd_op | output | 8 | Last command opcode |
| srst_o | output | 1 | Soft reset level from Device Control |
| fw_feat | output | 8 | Features register |
| fw_count | output | 8 | Sector count register |
| fw_sect | output | 8 | Sector number register |
| fw_cyl | output | 16 | Cylinder high and low |
| fw_devhead | output | 8 | Device/head register |

## Verification
The bench checks that the control-register read returns Status without consuming the interrupt. A design that shared the clear path between the two status reads would drop `irq_o` there. The bench writes the task-file while deselected and then checks what was stored. It also issues a Command write to the other device, which must start nothing and must not clear the pending interrupt. A design that gated every write by selection, or none of them, would fail one of those two checks. The bench sets the interrupt-disable bit and clears it again: a design that discarded the pending request under the mask would show no interrupt once the mask lifts. Last, the bench probes decode holes: the data address, unused control addresses and both chip selects at once. Each must leave the bus undriven.

// File: rtl/ata_taskfile.sv
module ata_taskfile #(
  parameter bit         DEV_ID      = 1'b0,
  parameter logic [7:0] DIAG_CODE   = 8'h01,
  parameter logic [7:0] STATUS_INIT = 8'h40,
  parameter int         DEV_BIT     = 4,
  parameter int         NIEN_BIT    = 1,
  parameter int         SRST_BIT    = 2,
  parameter int         BSY_BIT     = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_cmd,
  input  logic        cs_ctl,
  input  logic [2:0]  addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        rdata_oe,
  output logic        irq_o,
  output logic        irq_oe,
  input  logic        fw_status_we,
  input  logic [7:0]  fw_status,
  input  logic        fw_error_we,
  input  logic [7:0]  fw_error,
  input  logic        fw_irq_set,
  output logic        cmd_go,
  output logic [7:0]  cmd_op,
  output logic        srst_o,
  output logic [7:0]  fw_feat,
  output logic [7:0]  fw_count,
  output logic [7:0]  fw_sect,
  output logic [15:0] fw_cyl,
  output logic [7:0]  fw_devhead
);
  localparam logic [2:0] A_ERR = 3'd1, A_CNT = 3'd2, A_SEC = 3'd3,
                         A_CLO = 3'd4, A_CHI = 3'd5, A_DH  = 3'd6,
                         A_CMD = 3'd7, A_CTL = 3'd6;

  logic [7:0] status_q, error_q, devctl_q;
  logic       pend;

  wire blk_cmd = cs_cmd & ~cs_ctl;
  wire blk_ctl = cs_ctl & ~cs_cmd;
  wire sel     = (fw_devhead[DEV_BIT] == DEV_ID);
  wire hw_w    = wr_en & blk_cmd;
  wire wr_cmd  = hw_w & (addr == A_CMD) & sel;
  wire rd_stat = rd_en & blk_cmd & (addr == A_CMD) & sel;
  wire wr_dc   = wr_en & blk_ctl & (addr == A_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_feat    <= '0;
      fw_count   <= '0;
      fw_sect    <= '0;
      fw_cyl     <= '0;
      fw_devhead <= '0;
      devctl_q   <= '0;
    end else begin
      if (hw_w && addr == A_ERR) fw_feat        <= wdata;
      if (hw_w && addr == A_CNT) fw_count       <= wdata;
      if (hw_w && addr == A_SEC) fw_sect        <= wdata;
      if (hw_w && addr == A_CLO) fw_cyl[7:0]    <= wdata;
      if (hw_w && addr == A_CHI) fw_cyl[15:8]   <= wdata;
      if (hw_w && addr == A_DH)  fw_devhead     <= wdata;
      if (wr_dc)                 devctl_q       <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STATUS_INIT;
      error_q  <= DIAG_CODE;
      cmd_go   <= 1'b0;
      cmd_op   <= '0;
      pend     <= 1'b0;
    end else begin
      cmd_go <= wr_cmd;
      if (wr_cmd) begin
        cmd_op            <= wdata;
        status_q[BSY_BIT] <= 1'b1;
      end
      if (fw_status_we) status_q <= fw_status;
      if (fw_error_we)  error_q  <= fw_error;
      if (fw_irq_set)
        pend <= 1'b1;
      else if (wr_cmd || rd_stat || (wr_dc && wdata[SRST_BIT]))
        pend <= 1'b0;
    end
  end

  logic       hit;
  logic [7:0] mux;
  always_comb begin
    hit = 1'b0;
    mux = '0;
    if (blk_cmd) begin
      hit = 1'b1;
      case (addr)
        A_ERR:   mux = error_q;
        A_CNT:   mux = fw_count;
        A_SEC:   mux = fw_sect;
        A_CLO:   mux = fw_cyl[7:0];
        A_CHI:   mux = fw_cyl[15:8];
        A_DH:    mux = fw_devhead;
        A_CMD:   mux = status_q;
        default: hit = 1'b0;
      endcase
    end else if (blk_ctl && addr == A_CTL) begin
      hit = 1'b1;
      mux = status_q;
    end
  end

  assign rdata_oe = rd_en & sel & hit;
  assign rdata    = rdata_oe ? mux : '0;
  assign irq_oe   = sel & ~devctl_q[NIEN_BIT];
  assign irq_o    = irq_oe & pend;
  assign srst_o   = devctl_q[SRST_BIT];
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_cmd,
  input logic       cs_ctl,
  input logic [2:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       rdata_oe,
  input logic       irq_oe,
  input logic       cmd_go,
  input logic       fw_irq_set,
  input logic       pend,
  input logic       sel
);
  wire only_cmd = cs_cmd & ~cs_ctl;
  wire only_ctl = cs_ctl & ~cs_cmd;

  p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> !rdata_oe);
  p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!irq_oe && !rdata_oe));
  p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && only_cmd && addr == 3'd7) |=> cmd_go);
  p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fw_irq_set |=> pend);
  p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd_en && only_cmd && addr == 3'd7 && !fw_irq_set) |=> !pend);
  p_alt_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && only_ctl && addr == 3'd6 && pend) |=> pend);
  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && only_ctl && addr == 3'd6 && wdata[1]) |=> !irq_oe);
endmodule

bind ata_taskfile ata_taskfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .addr(addr),
  .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata_oe(rdata_oe),
  .irq_oe(irq_oe), .cmd_go(cmd_go), .fw_irq_set(fw_irq_set),
  .pend(pend), .sel(sel)
);

// File: tb/ata_taskfile_tb_top.sv
module ata_taskfile_tb_top;
  logic clk = 0, rst_n = 0;
  logic cs_cmd = 0, cs_ctl = 0, rd_en = 0, wr_en = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic rdata_oe, irq_o, irq_oe, cmd_go, srst_o;
  logic fw_status_we = 0, fw_error_we = 0, fw_irq_set = 0;
  logic [7:0] fw_status = '0, fw_error = '0, cmd_op, fw_feat, fw_count, fw_sect, fw_devhead;
  logic [15:0] fw_cyl;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ata_taskfile dut_i (.*);

  // {req[3:0], wr, cs{ctl,cmd}[1:0], addr[2:0], data[7:0], expect_oe}
  localparam int NV = 20;
  localparam logic [18:0] VEC [NV] = '{
    {4'd1, 1'b1, 2'b01, 3'd2, 8'h12, 1'b0},  // R1
    {4'd1, 1'b0, 2'b01, 3'd2, 8'h12, 1'b1},
    {4'd1, 1'b1, 2'b01, 3'd3, 8'h34, 1'b0},
    {4'd1, 1'b0, 2'b01, 3'd3, 8'h34, 1'b1},
    {4'd1, 1'b1, 2'b01, 3'd4, 8'h56, 1'b0},
    {4'd1, 1'b0, 2'b01, 3'd4, 8'h56, 1'b1},
    {4'd1, 1'b1, 2'b01, 3'd5, 8'h78, 1'b0},
    {4'd1, 1'b0, 2'b01, 3'd5, 8'h78, 1'b1},
    {4'd1, 1'b1, 2'b01, 3'd6, 8'hA0, 1'b0},
    {4'd1, 1'b0, 2'b01, 3'd6, 8'hA0, 1'b1},
    {4'd4, 1'b0, 2'b01, 3'd7, 8'h40, 1'b1},  // R4 status reset
    {4'd4, 1'b0, 2'b01, 3'd1, 8'h01, 1'b1},  // R4 error diag
    {4'd8, 1'b0, 2'b10, 3'd6, 8'h40, 1'b1},  // R8 alternate status
    {4'd2, 1'b0, 2'b10, 3'd5, 8'h00, 1'b0},  // R2 unused control addr
    {4'd2, 1'b0, 2'b11, 3'd7, 8'h00, 1'b0},  // R2 both selects
    {4'd2, 1'b0, 2'b00, 3'd2, 8'h00, 1'b0},  // R2 no select
    {4'd11,1'b1, 2'b01, 3'd0, 8'hEE, 1'b0},  // R11 data write
    {4'd11,1'b0, 2'b01, 3'd0, 8'h00, 1'b0},  // R11 data read
    {4'd10,1'b1, 2'b01, 3'd1, 8'h99, 1'b0},  // R10 features write
    {4'd10,1'b0, 2'b01, 3'd1, 8'h01, 1'b1}   // R10 error unchanged
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] cs, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    {cs_ctl, cs_cmd} = cs; addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0; {cs_ctl, cs_cmd} = 2'b00;
  endtask

  task automatic hrd(input logic [1:0] cs, input logic [2:0] a,
                     output logic [7:0] d, output logic oe);
    @(negedge clk);
    {cs_ctl, cs_cmd} = cs; addr = a; rd_en = 1;
    #5 d = rdata; oe = rdata_oe;
    @(posedge clk); #1;
    rd_en = 0; {cs_ctl, cs_cmd} = 2'b00;
  endtask

  task automatic raise;
    @(negedge clk); fw_irq_set = 1;
    @(posedge clk); #1 fw_irq_set = 0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      summary();
    end
  end

  initial begin
    logic [7:0] d; logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5 chk("R6 reset irq", {14'd0, irq_oe, irq_o}, 16'h0002);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][14]) hwr(VEC[i][13:12], VEC[i][11:9], VEC[i][8:1]);
      else begin
        hrd(VEC[i][13:12], VEC[i][11:9], d, oe);
        chk($sformatf("R%0d vec%0d oe", VEC[i][18:15], i), {15'd0, oe}, {15'd0, VEC[i][0]});
        if (VEC[i][0]) chk($sformatf("R%0d vec%0d data", VEC[i][18:15], i), {8'd0, d}, {8'd0, VEC[i][8:1]});
      end
    end
    chk("R10 features out", {8'd0, fw_feat}, 16'h0099);
    chk("R1 cylinder out", fw_cyl, 16'h7856);

    // R6 raise, R8 alt keeps, R7 status read clears
    raise();
    chk("R6 irq raised", {15'd0, irq_o}, 16'd1);
    hrd(2'b10, 3'd6, d, oe);
    chk("R8 alt keeps irq", {15'd0, irq_o}, 16'd1);
    hrd(2'b01, 3'd7, d, oe);
    chk("R7 status read clears", {15'd0, irq_o}, 16'd0);

    // R5 command write, R7 command clears
    raise();
    hwr(2'b01, 3'd7, 8'h20);
    chk("R5 cmd_go pulse", {7'd0, cmd_go, cmd_op}, 16'h0120);
    chk("R7 command clears", {15'd0, irq_o}, 16'd0);
    @(posedge clk); #1;
    chk("R5 cmd_go one cycle", {15'd0, cmd_go}, 16'd0);
    hrd(2'b01, 3'd7, d, oe);
    chk("R5 BSY set", {8'd0, d}, 16'h00C0);

    // R5 firmware status load, R10 error load
    @(negedge clk); fw_status = 8'h51; fw_status_we = 1; fw_error = 8'h04; fw_error_we = 1;
    @(posedge clk); #1 fw_status_we = 0; fw_error_we = 0;
    hrd(2'b01, 3'd7, d, oe);
    chk("R5 firmware status", {8'd0, d}, 16'h0051);
    hrd(2'b01, 3'd1, d, oe);
    chk("R10 error load", {8'd0, d}, 16'h0004);

    // R9 masking keeps pending
    raise();
    hwr(2'b10, 3'd6, 8'h02);
    chk("R9 masked oe", {15'd0, irq_oe}, 16'd0);
    hwr(2'b10, 3'd5, 8'h00);
    chk("R2 unused ctl write ignored", {15'd0, irq_oe}, 16'd0);
    hwr(2'b10, 3'd6, 8'h00);
    chk("R9 unmask shows pending", {14'd0, irq_oe, irq_o}, 16'h0003);
    hwr(2'b10, 3'd6, 8'h04);
    chk("R7 srst clears", {14'd0, srst_o, irq_o}, 16'h0002);
    hwr(2'b10, 3'd6, 8'h00);

    // R3 deselection
    raise();
    hwr(2'b01, 3'd6, 8'hB0);
    hrd(2'b01, 3'd2, d, oe);
    chk("R3 deselected read", {15'd0, oe}, 16'd0);
    chk("R3 deselected irq_oe", {15'd0, irq_oe}, 16'd0);
    hwr(2'b01, 3'd7, 8'h30);
    chk("R3 no cmd_go", {15'd0, cmd_go}, 16'd0);
    hwr(2'b01, 3'd2, 8'h55);
    hwr(2'b01, 3'd6, 8'hA0);
    hrd(2'b01, 3'd2, d, oe);
    chk("R3 shadow write kept", {7'd0, oe, d}, 16'h0155);
    chk("R3 irq survives other cmd", {15'd0, irq_o}, 16'd1);

    // R7 hardware reset clears, R4 reset values
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    #5 chk("R7 reset clears irq", {15'd0, irq_o}, 16'd0);
    hrd(2'b01, 3'd7, d, oe);
    chk("R4 status after reset", {8'd0, d}, 16'h0040);
    hrd(2'b01, 3'd1, d, oe);
    chk("R4 error after reset", {8'd0, d}, 16'h0001);

    done = 1;
    summary();
  end
endmodule